// File: doc/BRIEF.md
# Debounced Edge Interrupt Detector

This block conditions one raw pad input for interrupt use. The pad is first brought into the clock domain by a short chain of flops. A debounce filter then cleans it, if enabled. Finally an edge detector turns transitions of the filtered level into single-cycle event pulses. Each pulse is meant to set the pin's interrupt status bit in a separate status register.

The block reads its settings from the pin's control word. A two-bit trigger field selects rising, falling or both edges, or no events at all. An enable bit switches the debounce filter on. A three-bit exponent sets the settle time to 2^n ticks of an external 1 ms strobe, so the time runs from 1 ms to 128 ms.

The filtered level is also the value that software sees as the pin's input state. Changing the debounce settings re-seeds the filter from the current synchronized input. This re-seeding never produces an event.

Top module: `pin_edge_detector`

## Requirements
- R1: While reset is held and in the first cycle after it, `level_out` is 0 and `edge_evt` is 0.
- R2: With debounce off, a change on `pad_in` that is set up before clock edge k shows on `level_out` after edge k+2. `level_out` still has the old value after edge k+1. This comes from two synchronizer flops and one filter flop.
- R3: The trigger field is `ctrl_word[4:3]`. A value of 1 raises `edge_evt` for a 0-to-1 change of `level_out`, 2 for a 1-to-0 change, and 3 for either. The pulse lasts the single cycle after the change.
- R4: With a trigger field of 0, `edge_evt` stays 0 whatever the input does.
- R5: Debounce is enabled by `ctrl_word[8]`, and the exponent n is `ctrl_word[7:5]`. When enabled, `level_out` takes a new value only on the clock edge that samples the 2^n-th `ms_tick` pulse. Every one of those pulses must arrive while the synchronized input differs from `level_out`.
- R6: If the synchronized input returns to `level_out` before the count completes, the count restarts from zero.
- R7: With `ctrl_word[8]` at 0, the exponent field has no effect and the synchronized input is copied to `level_out` every cycle.
- R8: A change of the enable bit, or of the exponent while enabled, loads `level_out` from the synchronized input on the next edge. It produces no `edge_evt` in that cycle or the one after.
- R9: A pad pulse shorter than the settle time leaves `level_out` unchanged and produces no `edge_evt`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctrl_word | input | CTRL_W (32) | Pin control word: trigger [4:3], exponent [7:5], debounce enable [8] |
| ms_tick | input | 1 | One-cycle strobe, once per millisecond |
| pad_in | input | 1 | Raw asynchronous pad level |
| level_out | output | 1 | Filtered pin level, used for input readback |
| edge_evt | output | 1 | One-cycle event pulse for the interrupt status bit |

## Verification
The bench builds the block with its default parameters: a 32-bit control word and two synchronizer stages. This fixes the pad-to-level latency at three edges, which the directed checks count exactly. Since the tick strobe comes from the bench, it can fire on every cycle. That brings the largest exponent, 128 ticks, within a few hundred cycles, along with the exact boundary cycle for the smaller exponents. Random phases change the trigger, enable and exponent fields while the pad is moving. This exercises the reload path against settle counts that are part way through.

// File: rtl/pin_evt_pkg.sv
package pin_evt_pkg;
  localparam int TRIG_LSB = 3;
  localparam int RATE_LSB = 5;
  localparam int DBEN_BIT = 8;
  localparam int RATE_W   = 3;
  localparam int CNT_W    = 1 << RATE_W;

  typedef enum logic [1:0] {
    TRIG_OFF  = 2'd0,
    TRIG_RISE = 2'd1,
    TRIG_FALL = 2'd2,
    TRIG_BOTH = 2'd3
  } trig_e;

  // number of ticks the new level must hold
  function automatic logic [CNT_W:0] hold_ticks(input logic [RATE_W-1:0] expo);
    return (CNT_W+1)'(1) << expo;
  endfunction

  function automatic logic edge_hit(input trig_e t, input logic prev, input logic cur);
    return (t[0] & ~prev & cur) | (t[1] & prev & ~cur);
  endfunction
endpackage

// File: rtl/pin_sync.sv
module pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/pin_debounce.sv
module pin_debounce
  import pin_evt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sync_in,
  input  logic              deb_en,
  input  logic [RATE_W-1:0] expo,
  input  logic              ms_tick,
  output logic              filt_out,
  output logic              reload_o
);
  logic [RATE_W:0]  cfg_now, cfg_q;
  logic [CNT_W:0]   run_cnt, run_nxt;
  logic             differs;

  // exponent only counts while filtering is on
  assign cfg_now  = deb_en ? {1'b1, expo} : '0;
  assign reload_o = (cfg_now != cfg_q);
  assign differs  = (sync_in != filt_out);
  assign run_nxt  = run_cnt + 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_q    <= '0;
      filt_out <= 1'b0;
      run_cnt  <= '0;
    end else begin
      cfg_q <= cfg_now;
      if (reload_o || !deb_en) begin
        filt_out <= sync_in;
        run_cnt  <= '0;
      end else if (!differs) begin
        run_cnt <= '0;
      end else if (ms_tick) begin
        if (run_nxt == hold_ticks(expo)) begin
          filt_out <= sync_in;
          run_cnt  <= '0;
        end else begin
          run_cnt <= run_nxt;
        end
      end
    end
  end
endmodule

// File: rtl/pin_edge_gen.sv
module pin_edge_gen
  import pin_evt_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  trig_e trig,
  input  logic  level,
  input  logic  reload,
  output logic  evt
);
  logic prev_q, quiet_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_q  <= 1'b0;
      quiet_q <= 1'b0;
    end else begin
      prev_q  <= level;
      quiet_q <= reload;
    end
  end

  assign evt = edge_hit(trig, prev_q, level) & ~quiet_q;
endmodule

// File: rtl/pin_edge_detector.sv
module pin_edge_detector
  import pin_evt_pkg::*;
#(
  parameter int CTRL_W      = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CTRL_W-1:0] ctrl_word,
  input  logic              ms_tick,
  input  logic              pad_in,
  output logic              level_out,
  output logic              edge_evt
);
  logic              sync_w;
  logic              reload_w;
  logic              deb_en_w;
  logic [RATE_W-1:0] expo_w;
  trig_e             trig_w;

  assign deb_en_w = ctrl_word[DBEN_BIT];
  assign expo_w   = ctrl_word[RATE_LSB +: RATE_W];
  assign trig_w   = trig_e'(ctrl_word[TRIG_LSB +: 2]);

  pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pad_in), .q(sync_w)
  );

  pin_debounce u_deb (
    .clk(clk), .rst_n(rst_n), .sync_in(sync_w), .deb_en(deb_en_w),
    .expo(expo_w), .ms_tick(ms_tick), .filt_out(level_out), .reload_o(reload_w)
  );

  pin_edge_gen u_edge (
    .clk(clk), .rst_n(rst_n), .trig(trig_w), .level(level_out),
    .reload(reload_w), .evt(edge_evt)
  );
endmodule

// File: rtl/pin_edge_checker.sv
module pin_edge_checker (
  input logic       clk,
  input logic       rst_n,
  input logic [4:3] trig_bits,
  input logic       ms_tick,
  input logic       level_out,
  input logic       edge_evt,
  input logic       reload_w,
  input logic       deb_en_w
);
  AST_NO_EVT_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_bits == 2'b00) |-> !edge_evt); // R4

  AST_EVT_NEEDS_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
    edge_evt |-> (level_out != $past(level_out))); // R3

  AST_EVT_MATCHES_DIR: assert property (@(posedge clk) disable iff (!rst_n)
    edge_evt |-> ((trig_bits[3] && level_out) || (trig_bits[4] && !level_out))); // R3

  AST_FILTER_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    ((level_out != $past(level_out)) && $past(deb_en_w) && !$past(reload_w))
      |-> $past(ms_tick)); // R5

  AST_RELOAD_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    $past(reload_w) |-> !edge_evt); // R8
endmodule

bind pin_edge_detector pin_edge_checker u_chk (
  .clk(clk), .rst_n(rst_n), .trig_bits(ctrl_word[4:3]), .ms_tick(ms_tick),
  .level_out(level_out), .edge_evt(edge_evt), .reload_w(reload_w),
  .deb_en_w(deb_en_w)
);

// File: tb/sim_pin_edge_detector.sv
`timescale 1ns/1ps
module sim_pin_edge_detector;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] ctrl = '0;
  logic        tick = 1'b0;
  logic        pad = 1'b0;
  logic        level_out, edge_evt;
  int          checks = 0, errors = 0;
  bit          tick_always = 1'b0;
  bit          done = 1'b0;

  always #5 clk = ~clk;

  pin_edge_detector u0 (
    .clk(clk), .rst_n(rst_n), .ctrl_word(ctrl), .ms_tick(tick),
    .pad_in(pad), .level_out(level_out), .edge_evt(edge_evt)
  );

  // reference model, from the requirements
  logic       m_s0, m_s1, m_lvl, m_prev, m_quiet;
  logic [3:0] m_key_q, m_key;
  int         m_run;
  assign m_key = ctrl[8] ? {1'b1, ctrl[7:5]} : 4'd0;

  function automatic bit exp_evt(logic [1:0] tr, logic pv, logic cu, logic qt);
    if (qt) return 1'b0;
    return (tr[0] && !pv && cu) || (tr[1] && pv && !cu);
  endfunction

  function automatic int settle(logic [2:0] e);
    return 1 << e;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_s0 <= 0; m_s1 <= 0; m_lvl <= 0; m_prev <= 0; m_quiet <= 0;
      m_key_q <= 0; m_run <= 0;
    end else begin
      m_s0 <= pad; m_s1 <= m_s0;
      m_key_q <= m_key;
      m_prev <= m_lvl;
      m_quiet <= (m_key != m_key_q);
      if (!ctrl[8] || (m_key != m_key_q)) begin
        m_lvl <= m_s1; m_run <= 0;
      end else if (m_s1 == m_lvl) begin
        m_run <= 0;
      end else if (tick) begin
        if (m_run + 1 >= settle(ctrl[7:5])) begin m_lvl <= m_s1; m_run <= 0; end
        else m_run <= m_run + 1;
      end
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp, string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  // one cycle: wait past the edge, compare with the model, then set the tick
  task automatic adv();
    @(posedge clk); #2;
    if (rst_n) begin
      chk(ctrl[8] ? "R5" : "R7", level_out, m_lvl, "model level");
      chk("R3", edge_evt, exp_evt(ctrl[4:3], m_prev, m_lvl, m_quiet), "model event");
    end
    tick = tick_always ? 1'b1 : ($urandom_range(0, 2) == 0);
  endtask

  task automatic advn(int n);
    for (int i = 0; i < n; i++) adv();
  endtask

  function automatic logic [31:0] mk(bit en, logic [2:0] e, logic [1:0] tr);
    return {23'd0, en, e, tr, 3'd0};
  endfunction

  initial begin
    #(200000 * 10);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    bit saw;
    void'($urandom(32'd20240611));
    advn(3);
    chk("R1", level_out, 0, "level in reset");
    chk("R1", edge_evt, 0, "event in reset");
    rst_n = 1'b1;
    adv();
    chk("R1", level_out, 0, "level after reset");
    chk("R1", edge_evt, 0, "event after reset");

    // R2 latency and R3 rising pulse, debounce off
    ctrl = mk(0, 3'd0, 2'd1); advn(2);
    pad = 1; adv(); adv();
    chk("R2", level_out, 0, "level after two edges");
    adv();
    chk("R2", level_out, 1, "level after three edges");
    chk("R3", edge_evt, 1, "rising pulse");
    adv();
    chk("R3", edge_evt, 0, "pulse lasts one cycle");

    // R4 trigger off: toggles give no event
    ctrl = mk(0, 3'd0, 2'd0); adv();
    saw = 0;
    pad = 0; for (int i = 0; i < 4; i++) begin adv(); saw |= edge_evt; end
    pad = 1; for (int i = 0; i < 4; i++) begin adv(); saw |= edge_evt; end
    chk("R4", saw, 0, "no event with trigger off");

    // R7 exponent ignored when disabled
    ctrl = mk(0, 3'd7, 2'd2); adv();
    pad = 0; advn(3);
    chk("R7", level_out, 0, "pass-through with exponent 7");
    chk("R3", edge_evt, 1, "falling pulse");

    // R5 settle of 4 ticks
    tick_always = 1; tick = 1;
    ctrl = mk(1, 3'd2, 2'd3); advn(2);
    pad = 1; advn(2 + settle(3'd2) - 1);
    chk("R5", level_out, 0, "level before count done");
    adv();
    chk("R5", level_out, 1, "level after 4 ticks");
    chk("R3", edge_evt, 1, "both-edge pulse");

    // R9 short glitch, R6 restart
    pad = 0; advn(2); pad = 1;
    saw = 0;
    for (int i = 0; i < 10; i++) begin adv(); saw |= edge_evt; end
    chk("R9", level_out, 1, "glitch filtered");
    chk("R9", saw, 0, "no event on glitch");
    pad = 0; advn(3); pad = 1; advn(2); pad = 0;
    advn(2 + settle(3'd2) - 1);
    chk("R6", level_out, 1, "count restarted");
    adv();
    chk("R6", level_out, 0, "full count after restart");

    // R8 reload on exponent change, no event
    advn(2);
    pad = 1; advn(3);
    chk("R8", level_out, 0, "mid count");
    ctrl = mk(1, 3'd3, 2'd3); adv();
    chk("R8", level_out, 1, "reloaded from input");
    chk("R8", edge_evt, 0, "no event on reload");
    adv();
    chk("R8", edge_evt, 0, "no event after reload");

    // R5 longest settle, 128 ticks
    ctrl = mk(1, 3'd7, 2'd3); advn(2);
    pad = 0; advn(2 + settle(3'd7) - 1);
    chk("R5", level_out, 1, "level before 128 ticks");
    adv();
    chk("R5", level_out, 0, "level after 128 ticks");

    // random phase
    tick_always = 0;
    for (int blk = 0; blk < 60; blk++) begin
      if ($urandom_range(0, 3) == 0)
        ctrl = mk($urandom_range(0, 1), $urandom_range(0, 3), $urandom_range(0, 3));
      for (int j = 0; j < 8; j++) begin
        pad = $urandom_range(0, 1);
        advn($urandom_range(1, 12));
      end
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule